// File: doc/BRIEF.md
# Multiplexed Bus Address Latch and Data Steering Unit

This block sits between a processor whose low address byte and top address nibble share pins with data and status signals, and a byte-wide memory array. In the first clock state of every four-state bus cycle the processor raises its address-latch-enable strobe and places the full 20-bit address on its pins. The block passes that address straight through while the strobe is high and keeps the last sampled value once the strobe drops. The memory therefore sees a steady address through the remaining states, while the shared pins go on to carry data and status.

The block also steers the byte-wide data path. A transceiver-enable input and a direction input decide whether processor data is driven toward memory, memory data is driven back toward the processor, or neither side is driven. Tri-state drivers are represented by enable flags. The read and write strobes reach memory only when the memory/I-O select input marks the cycle as a memory cycle. Electrical buffering and drive strength are not modelled.

Top module: `bus_demux`

## Requirements
- R1: While `ale` is 1, `addr` equals {`a_hi_st`, `a_mid`, `ad_in`} in the same cycle, with `a_hi_st` as bits 19:16, `a_mid` as bits 15:8 and `ad_in` as bits 7:0.
- R2: While `ale` is 0, `addr` holds the value the pins had at the last rising clock edge at which `ale` was 1. When `ale` stays high for several edges, the value at the last of those edges is the one kept.
- R3: While `ale` is 0, changes on `a_hi_st` (status bits at that point) and on `ad_in` (data at that point) leave `addr[19:16]` and `addr[7:0]` unchanged.
- R4: A synchronous active-high `rst` clears the held address, so `addr` reads 0 while `ale` is 0 after reset.
- R5: With `xcvr_en` 0, `mem_wdata_oe` and `proc_rdata_oe` are both 0.
- R6: With `xcvr_en` 1 and `dt_r` 1 (transmit), `mem_wdata_oe` is 1, `proc_rdata_oe` is 0 and `mem_wdata` equals `ad_in`.
- R7: With `xcvr_en` 1 and `dt_r` 0 (receive), `proc_rdata_oe` is 1, `mem_wdata_oe` is 0 and `proc_rdata` equals `mem_rdata`.
- R8: With `io_m` 1 (I/O cycle), `mem_rd_n` and `mem_wr_n` are both 1, whatever `rd_n` and `wr_n` are.
- R9: With `io_m` 0 (memory cycle), `mem_rd_n` follows `rd_n` and `mem_wr_n` follows `wr_n` in the same cycle.
- R10: A memory read cycle at address 70C12H keeps `addr` at 70C12H from T2 to T4, and the byte 30H from memory appears on `proc_rdata` with `proc_rdata_oe` set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ale | input | 1 | Address latch enable, high in T1 |
| ad_in | input | 8 | Shared pins: address 7:0, then data |
| a_mid | input | 8 | Address bits 15:8 |
| a_hi_st | input | 4 | Shared pins: address 19:16, then status |
| dt_r | input | 1 | Direction: 1 toward memory, 0 toward processor |
| xcvr_en | input | 1 | Data transceiver enable, active high |
| io_m | input | 1 | 1 for an I/O cycle, 0 for a memory cycle |
| rd_n | input | 1 | Processor read strobe, active low |
| wr_n | input | 1 | Processor write strobe, active low |
| mem_rdata | input | 8 | Data returned by memory |
| addr | output | 20 | Demultiplexed address to memory |
| mem_wdata | output | 8 | Data driven toward memory |
| mem_wdata_oe | output | 1 | Enable of the memory-side driver |
| proc_rdata | output | 8 | Data driven back to the processor pins |
| proc_rdata_oe | output | 1 | Enable of the processor-side driver |
| mem_rd_n | output | 1 | Qualified memory read strobe, active low |
| mem_wr_n | output | 1 | Qualified memory write strobe, active low |

## Verification
The only state in this block is the held address, so a wrong capture shows up at `addr` on the first cycle after `ale` falls, and it stays there for the whole of T2 to T4. A nibble taken from the live status or data pins instead of the holding register makes `addr` move with those pins within the same cycle. The steering and strobe paths are combinational, so a wrong enable or a leaked I/O-cycle strobe shows at the ports in the same cycle its inputs are applied.

// File: rtl/bus_demux_pkg.sv
package bus_demux_pkg;

    localparam int LO_W   = 8;
    localparam int MID_W  = 8;
    localparam int HI_W   = 4;
    localparam int ADDR_W = LO_W + MID_W + HI_W;
    localparam int DATA_W = LO_W;
    localparam int NSTRB  = 2;

    typedef struct packed {
        logic [HI_W-1:0]  hi;
        logic [MID_W-1:0] mid;
        logic [LO_W-1:0]  lo;
    } addr_t;

    typedef enum logic {
        DIR_TO_PROC = 1'b0,
        DIR_TO_MEM  = 1'b1
    } dir_e;

    typedef struct packed {
        logic to_mem;
        logic to_proc;
    } drv_en_t;

    function automatic addr_t join_addr(
        input logic [HI_W-1:0]  hi,
        input logic [MID_W-1:0] mid,
        input logic [LO_W-1:0]  lo
    );
        addr_t a;
        a.hi  = hi;
        a.mid = mid;
        a.lo  = lo;
        return a;
    endfunction

    function automatic drv_en_t steer(input logic en, input dir_e dir);
        drv_en_t d;
        d.to_mem  = en && (dir == DIR_TO_MEM);
        d.to_proc = en && (dir == DIR_TO_PROC);
        return d;
    endfunction

endpackage

// File: rtl/bdx_addr_latch.sv
module bdx_addr_latch
    import bus_demux_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ale,
    input  addr_t live,
    output addr_t addr
);

    addr_t held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (ale) begin
            held_q <= live;
        end
    end

    assign addr = ale ? live : held_q;

    // R2
    held_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !ale |=> $stable(held_q));

    // R2
    fall_value_chk: assert property (@(posedge clk) disable iff (rst)
        (!ale && $past(ale) && !$past(rst)) |-> (addr == $past(live)));

    // R1
    open_follow_chk: assert property (@(posedge clk) disable iff (rst)
        ale |-> (addr == live));

endmodule

// File: rtl/bdx_data_path.sv
module bdx_data_path
    import bus_demux_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              dir,
    input  logic [DATA_W-1:0] proc_side,
    input  logic [DATA_W-1:0] mem_side,
    output logic [DATA_W-1:0] to_mem,
    output logic              to_mem_oe,
    output logic [DATA_W-1:0] to_proc,
    output logic              to_proc_oe
);

    drv_en_t drv;

    always_comb begin
        drv = steer(en, dir_e'(dir));
    end

    assign to_mem     = proc_side;
    assign to_proc    = mem_side;
    assign to_mem_oe  = drv.to_mem;
    assign to_proc_oe = drv.to_proc;

    // R6
    no_contention_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({to_mem_oe, to_proc_oe}));

    // R5
    idle_float_chk: assert property (@(posedge clk) disable iff (rst)
        !en |-> (!to_mem_oe && !to_proc_oe));

endmodule

// File: rtl/bdx_strobe_gate.sv
module bdx_strobe_gate
    import bus_demux_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             io_cyc,
    input  logic [NSTRB-1:0] strb_n_in,
    output logic [NSTRB-1:0] strb_n_out
);

    for (genvar g = 0; g < NSTRB; g++) begin : g_strb
        assign strb_n_out[g] = strb_n_in[g] | io_cyc;
    end

    // R8
    io_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        io_cyc |-> (&strb_n_out));

    // R9
    mem_pass_chk: assert property (@(posedge clk) disable iff (rst)
        !io_cyc |-> (strb_n_out == strb_n_in));

endmodule

// File: rtl/bus_demux.sv
module bus_demux
    import bus_demux_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ale,
    input  logic [LO_W-1:0]   ad_in,
    input  logic [MID_W-1:0]  a_mid,
    input  logic [HI_W-1:0]   a_hi_st,
    input  logic              dt_r,
    input  logic              xcvr_en,
    input  logic              io_m,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_wdata_oe,
    output logic [DATA_W-1:0] proc_rdata,
    output logic              proc_rdata_oe,
    output logic              mem_rd_n,
    output logic              mem_wr_n
);

    addr_t            live_a;
    addr_t            out_a;
    logic [NSTRB-1:0] strb_in;
    logic [NSTRB-1:0] strb_out;

    assign live_a  = join_addr(a_hi_st, a_mid, ad_in);
    assign addr    = out_a;
    assign strb_in = {wr_n, rd_n};

    bdx_addr_latch u_latch (
        .clk  (clk),
        .rst  (rst),
        .ale  (ale),
        .live (live_a),
        .addr (out_a)
    );

    bdx_data_path u_data (
        .clk        (clk),
        .rst        (rst),
        .en         (xcvr_en),
        .dir        (dt_r),
        .proc_side  (ad_in),
        .mem_side   (mem_rdata),
        .to_mem     (mem_wdata),
        .to_mem_oe  (mem_wdata_oe),
        .to_proc    (proc_rdata),
        .to_proc_oe (proc_rdata_oe)
    );

    bdx_strobe_gate u_strb (
        .clk        (clk),
        .rst        (rst),
        .io_cyc     (io_m),
        .strb_n_in  (strb_in),
        .strb_n_out (strb_out)
    );

    assign mem_rd_n = strb_out[0];
    assign mem_wr_n = strb_out[1];

    // R3
    status_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (!ale && $past(!ale) && !$past(rst)) |-> $stable(addr));

endmodule

// File: tb/tb_bus_demux.sv
module tb_bus_demux;

    logic        clk = 1'b0;
    logic        rst;
    logic        ale;
    logic [7:0]  ad_in;
    logic [7:0]  a_mid;
    logic [3:0]  a_hi_st;
    logic        dt_r;
    logic        xcvr_en;
    logic        io_m;
    logic        rd_n;
    logic        wr_n;
    logic [7:0]  mem_rdata;
    logic [19:0] addr;
    logic [7:0]  mem_wdata;
    logic        mem_wdata_oe;
    logic [7:0]  proc_rdata;
    logic        proc_rdata_oe;
    logic        mem_rd_n;
    logic        mem_wr_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bus_demux dut (
        .clk(clk), .rst(rst), .ale(ale), .ad_in(ad_in), .a_mid(a_mid),
        .a_hi_st(a_hi_st), .dt_r(dt_r), .xcvr_en(xcvr_en), .io_m(io_m),
        .rd_n(rd_n), .wr_n(wr_n), .mem_rdata(mem_rdata), .addr(addr),
        .mem_wdata(mem_wdata), .mem_wdata_oe(mem_wdata_oe),
        .proc_rdata(proc_rdata), .proc_rdata_oe(proc_rdata_oe),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n)
    );

    typedef struct packed {
        logic        ale;
        logic [7:0]  ad;
        logic [7:0]  mid;
        logic [3:0]  hi;
        logic        dtr;
        logic        en;
        logic        iom;
        logic        rdn;
        logic        wrn;
        logic [7:0]  md;
        logic [19:0] eaddr;
        logic        ewoe;
        logic [7:0]  ewd;
        logic        eroe;
        logic [7:0]  erd;
        logic        emrd;
        logic        emwr;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 8'h12, 8'h0C, 4'h7, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 20'h70C12, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1},
        '{1'b0, 8'hFF, 8'h0C, 4'hA, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h30, 20'h70C12, 1'b0, 8'h00, 1'b1, 8'h30, 1'b0, 1'b1},
        '{1'b0, 8'h00, 8'h0C, 4'h5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h30, 20'h70C12, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1},
        '{1'b1, 8'h34, 8'h12, 4'h3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 20'h31234, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1},
        '{1'b0, 8'h5A, 8'h12, 4'h9, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 20'h31234, 1'b1, 8'h5A, 1'b0, 8'h00, 1'b1, 1'b1},
        '{1'b1, 8'hFF, 8'hFF, 4'hF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 20'hFFFFF, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1},
        '{1'b0, 8'hA5, 8'hFF, 4'h0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 20'hFFFFF, 1'b1, 8'hA5, 1'b0, 8'h00, 1'b1, 1'b0},
        '{1'b0, 8'hC3, 8'hFF, 4'h6, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h3C, 20'hFFFFF, 1'b0, 8'h00, 1'b1, 8'h3C, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic a, input logic [7:0] lo, input logic [7:0] mid,
                         input logic [3:0] hi, input logic dir, input logic en,
                         input logic iom, input logic r, input logic w,
                         input logic [7:0] md);
        @(negedge clk);
        ale = a; ad_in = lo; a_mid = mid; a_hi_st = hi; dt_r = dir;
        xcvr_en = en; io_m = iom; rd_n = r; wr_n = w; mem_rdata = md;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        ale = 1'b0; ad_in = '0; a_mid = '0; a_hi_st = '0; dt_r = 1'b0;
        xcvr_en = 1'b0; io_m = 1'b0; rd_n = 1'b1; wr_n = 1'b1; mem_rdata = '0;
        repeat (3) @(posedge clk);
        #1;
        // R4: reset state
        chk("R4", "addr after reset", 32'(addr), 32'h0);
        chk("R5", "wdata_oe in reset", 32'(mem_wdata_oe), 32'h0);
        chk("R5", "rdata_oe in reset", 32'(proc_rdata_oe), 32'h0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].ale, TBL[i].ad, TBL[i].mid, TBL[i].hi, TBL[i].dtr,
                  TBL[i].en, TBL[i].iom, TBL[i].rdn, TBL[i].wrn, TBL[i].md);
            chk(TBL[i].ale ? "R1" : "R2", "addr", 32'(addr), 32'(TBL[i].eaddr));
            if (!TBL[i].ale)
                chk("R3", "addr hi nibble", 32'(addr[19:16]), 32'(TBL[i].eaddr[19:16]));
            chk(!TBL[i].en ? "R5" : (TBL[i].dtr ? "R6" : "R7"), "wdata_oe",
                32'(mem_wdata_oe), 32'(TBL[i].ewoe));
            chk(!TBL[i].en ? "R5" : (TBL[i].dtr ? "R6" : "R7"), "rdata_oe",
                32'(proc_rdata_oe), 32'(TBL[i].eroe));
            if (TBL[i].ewoe) chk("R6", "mem_wdata", 32'(mem_wdata), 32'(TBL[i].ewd));
            if (TBL[i].eroe) chk("R7", "proc_rdata", 32'(proc_rdata), 32'(TBL[i].erd));
            chk(TBL[i].iom ? "R8" : "R9", "mem_rd_n", 32'(mem_rd_n), 32'(TBL[i].emrd));
            chk(TBL[i].iom ? "R8" : "R9", "mem_wr_n", 32'(mem_wr_n), 32'(TBL[i].emwr));
        end

        // R10: full read cycle at 70C12H, T1 to T4
        drive(1'b1, 8'h12, 8'h0C, 4'h7, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
        chk("R10", "T1 addr", 32'(addr), 32'h70C12);
        drive(1'b0, 8'hEE, 8'h0C, 4'h3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00);
        chk("R10", "T2 addr", 32'(addr), 32'h70C12);
        chk("R10", "T2 mem_rd_n", 32'(mem_rd_n), 32'h0);
        drive(1'b0, 8'h30, 8'h0C, 4'hC, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h30);
        chk("R10", "T3 addr", 32'(addr), 32'h70C12);
        chk("R10", "T3 proc_rdata", 32'(proc_rdata), 32'h30);
        chk("R10", "T3 rdata_oe", 32'(proc_rdata_oe), 32'h1);
        drive(1'b0, 8'h30, 8'h0C, 4'hC, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h30);
        chk("R10", "T4 addr", 32'(addr), 32'h70C12);

        // R2: ALE high for two edges keeps the later value
        drive(1'b1, 8'h11, 8'h22, 4'h3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
        drive(1'b1, 8'h44, 8'h55, 4'h6, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
        drive(1'b0, 8'h99, 8'h55, 4'hE, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
        chk("R2", "long ale keeps last", 32'(addr), 32'h65544);
        // R3: data pins toggle while ALE low
        drive(1'b0, 8'h00, 8'h55, 4'h1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
        chk("R3", "low byte held", 32'(addr[7:0]), 32'h44);

        // R4: reset mid-operation clears held address
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        @(negedge clk);
        rst = 1'b0;
        ale = 1'b0;
        @(posedge clk);
        #1;
        chk("R4", "addr cleared", 32'(addr), 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule